// File: doc/BRIEF.md
# Halfword Shadowing Register Bridge

This block sits between a host register port that issues byte, halfword and word accesses and an SD host controller that only takes aligned 32-bit accesses. That controller also drops writes that arrive too close together while its card clock runs slowly.

Sub-word reads fetch the aligned word and return the addressed lane. Byte writes, and halfword writes to ordinary registers, become a read, a lane merge and a write-back. The two block-geometry halfwords and the transfer-mode halfword are kept in two local shadow words. When the command halfword is written, the shadows are sent downstream as at most two merged word writes, so the controller never sees two partial writes to the same word. After every downstream write the bridge waits for a gap that depends on the current card clock. The host handshake stays stalled during that gap.

Top module: `shw_bridge`

## Requirements
- R1: After reset, `req_ready` is high and `dn_req` and `rsp_valid` are low. Both shadow words are zero, so a first command halfword `V` produces exactly one downstream write of `V<<16` to 0x0C.
- R2: A read (`req_size` 0 = byte, 1 = halfword, 2 = word) issues one downstream read of the aligned word. The response is that word shifted right by 8 × `req_addr[1:0]` and masked to 8 or 16 bits. Word reads return the whole aligned word.
- R3: A halfword write to 0x04 (block size) or 0x06 (block count) is merged into the block shadow, which is laid out as the word at 0x04. It causes no downstream access.
- R4: A halfword write to 0x0C (transfer mode) is merged into the lower lane of the command shadow. It causes no downstream access.
- R5: A halfword write to 0x0E (command) with a nonzero block shadow first writes the block shadow to 0x04 and clears it. It then writes the command shadow, with the new value in bits 31:16, to 0x0C. The command shadow keeps its transfer-mode lane.
- R6: A command halfword write with a zero block shadow produces only the single write to 0x0C.
- R7: A byte write, or a halfword write to any other address, reads the aligned word and replaces only the addressed lane with the low bits of `req_wdata`. It writes the result back to the same aligned address.
- R8: A word write sends `req_wdata` unchanged to the aligned address, with no read.
- R9: After each downstream write acknowledge, `req_ready` stays low for a gap of G × (`SYS_CLK_HZ`/1e6) cycles. G is 10 µs when `sd_clk_hz` is 0, ceil(4e6/`sd_clk_hz`) µs when `sd_clk_hz` is at most 400000, and 0 otherwise.
- R10: `req_ready` is high only when no downstream access or gap is in progress. Each accepted request gives exactly one `rsp_valid` pulse.
- R11: `dn_req` with its address, direction and data is held steady until `dn_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_clk_hz | input | 32 | Current card clock frequency in Hz |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write value in low bits |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, zero for writes |
| dn_req | output | 1 | Downstream access request |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | ADDR_W | Aligned downstream address |
| dn_wdata | output | 32 | Downstream write word |
| dn_ack | input | 1 | Downstream access done |
| dn_rdata | input | 32 | Downstream read word, valid with ack |

## Verification
The bench sweeps every lane of every size on reads. A wrong shift or mask would return a neighbouring byte, and halfword lane 3 would show stray upper bits. Byte writes are swept across all four lanes: a merge that ignores the mask would corrupt the other lanes. The shadow sequence checks that no traffic leaves before the command and that the flush order is block first, then command. A design that skips the clear would emit a stale block write on the next command. The gap is measured in cycles across card clocks on both sides of the 400 kHz limit, at zero, and at a rate that needs rounding up; an off-by-one or truncating divide would shift the measured stall.

// File: rtl/shw_pkg.sv
package shw_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_GAP  = 2'd3
    } state_e;
endpackage

// File: rtl/shw_lane.sv
module shw_lane
    import shw_pkg::*;
(
    input  logic [WORD_W-1:0] old_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [1:0]        lane_i,
    input  size_e             size_i,
    output logic [WORD_W-1:0] merged_o,
    output logic [WORD_W-1:0] pick_o
);
    logic [WORD_W-1:0] mask;
    logic [4:0]        shamt;

    always_comb begin
        case (size_i)
            SZ_BYTE: mask = WORD_W'(32'h0000_00ff);
            SZ_HALF: mask = WORD_W'(32'h0000_ffff);
            default: mask = '1;
        endcase
        shamt    = (size_i == SZ_BYTE || size_i == SZ_HALF) ? {lane_i, 3'b000} : 5'd0;
        merged_o = (old_i & ~(mask << shamt)) | ((data_i & mask) << shamt);
        pick_o   = (old_i >> shamt) & mask;
    end
endmodule

// File: rtl/shw_gap.sv
module shw_gap #(
    parameter int unsigned SYS_CLK_HZ   = 100_000_000,
    parameter int unsigned SLOW_HZ      = 400_000,
    parameter int unsigned SLOW_PERIODS = 4,
    parameter int unsigned STOPPED_US   = 10,
    parameter int unsigned GAP_W        = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      sd_clk_hz,
    output logic [GAP_W-1:0] gap_cyc_o
);
    localparam longint unsigned CYC_PER_US =
        (SYS_CLK_HZ / 1_000_000 < 1) ? 1 : longint'(SYS_CLK_HZ / 1_000_000);
    localparam longint unsigned SPAN_US_HZ = longint'(SLOW_PERIODS) * 1_000_000;

    logic [63:0]      hz64;
    logic [63:0]      us_d;
    logic [GAP_W-1:0] gap_d, gap_q;

    always_comb begin
        hz64 = 64'(sd_clk_hz);
        if (hz64 == 64'd0)
            us_d = 64'(STOPPED_US);
        else if (hz64 <= 64'(SLOW_HZ))
            us_d = (SPAN_US_HZ + hz64 - 64'd1) / hz64;
        else
            us_d = 64'd0;
        gap_d = GAP_W'(us_d * CYC_PER_US);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign gap_cyc_o = gap_q;
endmodule

// File: rtl/shw_bridge.sv
module shw_bridge
    import shw_pkg::*;
#(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned SYS_CLK_HZ    = 100_000_000,
    parameter int unsigned SLOW_HZ       = 400_000,
    parameter int unsigned GAP_W         = 32,
    parameter logic [ADDR_W-1:0] BLK_SIZE_ADDR = ADDR_W'(8'h04),
    parameter logic [ADDR_W-1:0] BLK_CNT_ADDR  = ADDR_W'(8'h06),
    parameter logic [ADDR_W-1:0] XFER_ADDR     = ADDR_W'(8'h0C),
    parameter logic [ADDR_W-1:0] CMD_ADDR      = ADDR_W'(8'h0E)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       sd_clk_hz,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              dn_req,
    output logic              dn_we,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [31:0]       dn_wdata,
    input  logic              dn_ack,
    input  logic [31:0]       dn_rdata
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] BLK_WORD   = BLK_SIZE_ADDR & ALIGN_MASK;
    localparam logic [ADDR_W-1:0] CMD_WORD   = CMD_ADDR & ALIGN_MASK;

    typedef struct packed {
        state_e            st;
        logic [WORD_W-1:0] blk;
        logic [WORD_W-1:0] cmd;
        logic              dn_req;
        logic              dn_we;
        logic [ADDR_W-1:0] dn_addr;
        logic [WORD_W-1:0] dn_wdata;
        size_e             size;
        logic [1:0]        lane;
        logic [WORD_W-1:0] wdata;
        logic              rmw;
        logic              pend;
        logic [WORD_W-1:0] pend_word;
        logic [GAP_W-1:0]  cnt;
        logic              rsp_valid;
        logic [WORD_W-1:0] rsp_rdata;
    } regs_t;

    regs_t q, d;

    logic [GAP_W-1:0]  gap_cyc;
    logic [WORD_W-1:0] lane_old, lane_data, lane_merged, lane_pick;
    logic [1:0]        lane_sel;
    size_e             lane_size;
    size_e             host_size;
    logic              is_half, hit_blk, hit_xfer, hit_cmd;
    logic              finish;

    shw_gap #(
        .SYS_CLK_HZ (SYS_CLK_HZ),
        .SLOW_HZ    (SLOW_HZ),
        .GAP_W      (GAP_W)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_clk_hz (sd_clk_hz),
        .gap_cyc_o (gap_cyc)
    );

    shw_lane u_lane (
        .old_i    (lane_old),
        .data_i   (lane_data),
        .lane_i   (lane_sel),
        .size_i   (lane_size),
        .merged_o (lane_merged),
        .pick_o   (lane_pick)
    );

    always_comb begin
        host_size = size_e'(req_size);
        is_half   = (host_size == SZ_HALF);
        hit_blk   = is_half && (req_addr == BLK_SIZE_ADDR || req_addr == BLK_CNT_ADDR);
        hit_xfer  = is_half && (req_addr == XFER_ADDR);
        hit_cmd   = is_half && (req_addr == CMD_ADDR);

        // One lane unit: shadow merges while idle, read-back work otherwise
        if (q.st == ST_IDLE) begin
            lane_old  = (hit_xfer || hit_cmd) ? q.cmd : q.blk;
            lane_data = req_wdata;
            lane_sel  = req_addr[1:0];
            lane_size = host_size;
        end else begin
            lane_old  = dn_rdata;
            lane_data = q.wdata;
            lane_sel  = q.lane;
            lane_size = q.size;
        end
    end

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        finish      = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.size  = host_size;
                    d.lane  = req_addr[1:0];
                    d.wdata = req_wdata;
                    d.rmw   = 1'b0;
                    d.pend  = 1'b0;
                    if (!req_write) begin
                        d.dn_req  = 1'b1;
                        d.dn_we   = 1'b0;
                        d.dn_addr = req_addr & ALIGN_MASK;
                        d.st      = ST_RD;
                    end else if (host_size == SZ_WORD || req_size == 2'd3) begin
                        d.dn_req   = 1'b1;
                        d.dn_we    = 1'b1;
                        d.dn_addr  = req_addr & ALIGN_MASK;
                        d.dn_wdata = req_wdata;
                        d.st       = ST_WR;
                    end else if (hit_blk) begin
                        d.blk       = lane_merged;
                        d.rsp_valid = 1'b1;
                        d.rsp_rdata = '0;
                    end else if (hit_xfer) begin
                        d.cmd       = lane_merged;
                        d.rsp_valid = 1'b1;
                        d.rsp_rdata = '0;
                    end else if (hit_cmd) begin
                        d.dn_req = 1'b1;
                        d.dn_we  = 1'b1;
                        d.st     = ST_WR;
                        if (q.blk != '0) begin
                            d.dn_addr   = BLK_WORD;
                            d.dn_wdata  = q.blk;
                            d.blk       = '0;
                            d.pend      = 1'b1;
                            d.pend_word = lane_merged;
                        end else begin
                            d.dn_addr  = CMD_WORD;
                            d.dn_wdata = lane_merged;
                        end
                    end else begin
                        d.dn_req  = 1'b1;
                        d.dn_we   = 1'b0;
                        d.dn_addr = req_addr & ALIGN_MASK;
                        d.rmw     = 1'b1;
                        d.st      = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (dn_ack) begin
                    if (q.rmw) begin
                        d.dn_we    = 1'b1;
                        d.dn_wdata = lane_merged;
                        d.st       = ST_WR;
                    end else begin
                        d.dn_req    = 1'b0;
                        d.rsp_valid = 1'b1;
                        d.rsp_rdata = lane_pick;
                        d.st        = ST_IDLE;
                    end
                end
            end
            ST_WR: begin
                if (dn_ack) begin
                    d.dn_req = 1'b0;
                    d.dn_we  = 1'b0;
                    if (gap_cyc == '0) begin
                        finish = 1'b1;
                    end else begin
                        d.cnt = gap_cyc;
                        d.st  = ST_GAP;
                    end
                end
            end
            default: begin
                if (q.cnt <= GAP_W'(1)) finish = 1'b1;
                else                    d.cnt  = q.cnt - GAP_W'(1);
            end
        endcase

        if (finish) begin
            d.cnt = '0;
            if (q.pend) begin
                d.dn_req   = 1'b1;
                d.dn_we    = 1'b1;
                d.dn_addr  = CMD_WORD;
                d.dn_wdata = q.pend_word;
                d.pend     = 1'b0;
                d.st       = ST_WR;
            end else begin
                d.rsp_valid = 1'b1;
                d.rsp_rdata = '0;
                d.st        = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_valid;
    assign rsp_rdata = q.rsp_rdata;
    assign dn_req    = q.dn_req;
    assign dn_we     = q.dn_we;
    assign dn_addr   = q.dn_addr;
    assign dn_wdata  = q.dn_wdata;
endmodule

// File: rtl/shw_bridge_chk.sv
module shw_bridge_chk
    import shw_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SLOW_HZ = 400_000,
    parameter logic [ADDR_W-1:0] BLK_SIZE_ADDR = ADDR_W'(8'h04),
    parameter logic [ADDR_W-1:0] BLK_CNT_ADDR  = ADDR_W'(8'h06),
    parameter logic [ADDR_W-1:0] XFER_ADDR     = ADDR_W'(8'h0C)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       sd_clk_hz,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              dn_req,
    input logic              dn_we,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [31:0]       dn_wdata,
    input logic              dn_ack
);
    logic accept, shadow_hit;
    assign accept     = req_valid && req_ready;
    assign shadow_hit = req_write && req_size == 2'd1 &&
                        (req_addr == BLK_SIZE_ADDR || req_addr == BLK_CNT_ADDR ||
                         req_addr == XFER_ADDR);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !dn_req);

    a_r3_shadow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        accept && shadow_hit |=> !dn_req && req_ready);

    a_r2_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_write |=> dn_req && !dn_we);

    a_r7_byte_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && req_size == 2'd0 |=> dn_req && !dn_we);

    a_r8_word_direct: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && req_size == 2'd2 |=>
            dn_req && dn_we && dn_addr == ($past(req_addr) & ~ADDR_W'(3)));

    a_r9_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_we && dn_ack && sd_clk_hz <= SLOW_HZ && $stable(sd_clk_hz)
            |=> !req_ready && !dn_req);
endmodule

bind shw_bridge shw_bridge_chk #(
    .ADDR_W        (ADDR_W),
    .SLOW_HZ       (SLOW_HZ),
    .BLK_SIZE_ADDR (BLK_SIZE_ADDR),
    .BLK_CNT_ADDR  (BLK_CNT_ADDR),
    .XFER_ADDR     (XFER_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_clk_hz (sd_clk_hz),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .dn_req    (dn_req),
    .dn_we     (dn_we),
    .dn_addr   (dn_addr),
    .dn_wdata  (dn_wdata),
    .dn_ack    (dn_ack)
);

// File: tb/shw_bridge_tb.sv
module shw_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SYS_HZ     = 2_000_000;
    localparam int CPU        = SYS_HZ / 1_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sd_clk_hz = 32'd1_000_000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [31:0] req_wdata = 32'd0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        dn_req, dn_we;
    logic [7:0]  dn_addr;
    logic [31:0] dn_wdata;
    logic        dn_ack = 1'b0;
    logic [31:0] dn_rdata = 32'd0;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shw_bridge #(.ADDR_W(8), .SYS_CLK_HZ(SYS_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .sd_clk_hz(sd_clk_hz),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    // Downstream register model with a write log
    logic [31:0] mem [64];
    logic [7:0]  log_addr [128];
    logic [31:0] log_data [128];
    int          log_cyc  [128];
    int          log_n = 0;
    int          rd_n = 0;
    int          cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'd0;
            dn_ack <= 1'b0;
        end else if (dn_req && dn_ack) begin
            dn_ack <= 1'b0;
            if (dn_we) begin
                mem[dn_addr[7:2]] <= dn_wdata;
                log_addr[log_n]   <= dn_addr;
                log_data[log_n]   <= dn_wdata;
                log_cyc[log_n]    <= cyc;
                log_n             <= log_n + 1;
            end else begin
                rd_n <= rd_n + 1;
            end
        end else if (dn_req) begin
            dn_ack   <= 1'b1;
            dn_rdata <= mem[dn_addr[7:2]];
        end
    end

    // Protocol monitors for R10 and R11
    int   v10 = 0, v11 = 0;
    logic p_req = 1'b0, p_ack = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ready && dn_req) v10 <= v10 + 1;
            if (p_req && !p_ack && !dn_req) v11 <= v11 + 1;
        end
        p_req <= dn_req;
        p_ack <= dn_ack;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output int rc);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
        rc = cyc;
    endtask

    function automatic int gap_exp(input int unsigned hz);
        if (hz == 0) return 10 * CPU;
        if (hz <= 400_000) return int'((4_000_000 + hz - 1) / hz) * CPU;
        return 0;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] w, input logic [31:0] v,
                                          input int lane, input logic [31:0] m);
        return (w & ~(m << (lane * 8))) | ((v & m) << (lane * 8));
    endfunction

    initial begin
        repeat (100_000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd, w, exp;
        int rc, base, g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1 && dn_req == 1'b0 && rsp_valid == 1'b0, "R1 reset outputs",
              {29'd0, req_ready, dn_req, rsp_valid}, 32'h4);

        // R1/R6: empty shadows, single command write
        base = log_n;
        access(1, 2'd1, 8'h0E, 32'h1234, rd, rc);
        check(log_n == base + 1, "R6 single cmd write count", log_n - base, 1);
        check(log_addr[base] == 8'h0C && log_data[base] == 32'h1234_0000, "R1 zero shadow cmd word",
              log_data[base], 32'h1234_0000);

        // R8 word writes
        base = log_n;
        access(1, 2'd2, 8'h10, 32'hA1B2_C3D4, rd, rc);
        access(1, 2'd2, 8'h21, 32'h1122_3344, rd, rc);
        check(log_n == base + 2 && log_addr[base+1] == 8'h20, "R8 word write aligned",
              {24'd0, log_addr[base+1]}, 32'h20);
        check(log_data[base] == 32'hA1B2_C3D4, "R8 word data", log_data[base], 32'hA1B2_C3D4);

        // R2 read sweep
        base = log_n;
        w = 32'hA1B2_C3D4;
        for (int sz = 0; sz < 3; sz++) begin
            for (int l = 0; l < 4; l++) begin
                access(0, 2'(sz), 8'h10 + 8'(l), 32'd0, rd, rc);
                if (sz == 0)      exp = (w >> (l * 8)) & 32'hFF;
                else if (sz == 1) exp = (w >> (l * 8)) & 32'hFFFF;
                else              exp = w;
                check(rd == exp, $sformatf("R2 read size%0d lane%0d", sz, l), rd, exp);
            end
        end
        check(log_n == base, "R2 reads write nothing", log_n - base, 0);

        // R7 byte write sweep
        w = 32'h1122_3344;
        for (int l = 0; l < 4; l++) begin
            base = rd_n;
            access(1, 2'd0, 8'h20 + 8'(l), 32'hFFFF_FF50 + l, rd, rc);
            w = merge(w, 32'h50 + l, l, 32'hFF);
            check(rd_n == base + 1 && log_data[log_n-1] == w && log_addr[log_n-1] == 8'h20,
                  $sformatf("R7 byte rmw lane%0d", l), log_data[log_n-1], w);
        end
        access(1, 2'd1, 8'h22, 32'h0001_BEEF, rd, rc);
        w = merge(w, 32'hBEEF, 2, 32'hFFFF);
        check(log_data[log_n-1] == w, "R7 other halfword rmw", log_data[log_n-1], w);
        access(0, 2'd2, 8'h20, 32'd0, rd, rc);
        check(rd == w, "R7 readback", rd, w);

        // R3/R4 shadow writes
        base = log_n;
        access(1, 2'd1, 8'h04, 32'h0200, rd, rc);
        access(1, 2'd1, 8'h06, 32'h0003, rd, rc);
        access(1, 2'd1, 8'h0C, 32'h0011, rd, rc);
        check(log_n == base, "R3 R4 no downstream write", log_n - base, 0);
        access(0, 2'd2, 8'h0C, 32'd0, rd, rc);
        check(rd == 32'h1234_0000, "R4 xfer not sent", rd, 32'h1234_0000);
        access(0, 2'd2, 8'h04, 32'd0, rd, rc);
        check(rd == 32'd0, "R3 block not sent", rd, 32'd0);

        // R5 flush
        base = log_n;
        access(1, 2'd1, 8'h0E, 32'h3A1B, rd, rc);
        check(log_n == base + 2, "R5 flush count", log_n - base, 2);
        check(log_addr[base] == 8'h04 && log_data[base] == 32'h0003_0200, "R5 block first",
              log_data[base], 32'h0003_0200);
        check(log_addr[base+1] == 8'h0C && log_data[base+1] == 32'h3A1B_0011, "R5 cmd second",
              log_data[base+1], 32'h3A1B_0011);

        // R6 shadow cleared after flush
        base = log_n;
        access(1, 2'd1, 8'h0E, 32'h0C05, rd, rc);
        check(log_n == base + 1 && log_data[base] == 32'h0C05_0011, "R6 cleared block shadow",
              log_data[base], 32'h0C05_0011);

        // R9 gap sweep on word writes
        foreach (int_list_dummy[i]) ;
        for (int k = 0; k < 7; k++) begin
            int unsigned hz;
            case (k)
                0: hz = 1_000_000; 1: hz = 400_001; 2: hz = 400_000; 3: hz = 300_000;
                4: hz = 100_000;   5: hz = 250_000; default: hz = 0;
            endcase
            sd_clk_hz = hz;
            repeat (3) @(negedge clk);
            access(1, 2'd2, 8'h40, 32'h100 + k, rd, rc);
            g = gap_exp(hz);
            check(rc - log_cyc[log_n-1] == g + 1, $sformatf("R9 gap hz=%0d", hz),
                  rc - log_cyc[log_n-1], g + 1);
        end

        // R9 gap between flush writes
        sd_clk_hz = 200_000;
        repeat (3) @(negedge clk);
        g = gap_exp(200_000);
        access(1, 2'd1, 8'h04, 32'h0040, rd, rc);
        base = log_n;
        access(1, 2'd1, 8'h0E, 32'h1111, rd, rc);
        check(log_cyc[base+1] - log_cyc[base] == g + 2, "R9 gap between flush writes",
              log_cyc[base+1] - log_cyc[base], g + 2);
        check(rc - log_cyc[base+1] == g + 1, "R9 gap after cmd write",
              rc - log_cyc[base+1], g + 1);

        // R10/R11 monitors
        check(v10 == 0, "R10 ready while busy", v10, 0);
        check(v11 == 0, "R11 request dropped early", v11, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    int int_list_dummy [1];
endmodule